// File: doc/BRIEF.md
# Scaled-Add Integer Execute Stage

This block is the integer execute stage of a 64-bit load/store processor pipeline. Each accepted operation names two source operands. Operand A comes from a register-file read port. Operand B comes either from a second read port or from an 8-bit immediate that is zero-extended. The stage computes a 64-bit result and a destination write-enable. The operation set has five groups:

- plain and scaled (×4, ×8) add and subtract, each in a 64-bit form and a 32-bit form whose result is sign-extended to 64 bits;
- signed and unsigned compares that produce 0 or 1;
- a six-member bitwise logic group;
- three shifts;
- eight conditional-move predicates that test operand A against zero.

Operations enter through a valid/ready stream and leave one register stage later through a second valid/ready stream.

Back-pressure rules:

- The input is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output register is empty, or when it is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output register keeps its contents and no new operation is taken.

For the conditional moves, the result always carries operand B, and `out_wr_en` says whether the destination is to be written.

Top module: `int_exec_unit`

## Requirements
- R1: The 64-bit add/subtract group computes `(A << s) + B` or `(A << s) - B` modulo 2^64, where s is 0, 2 or 3. Its op codes are 0..11, decoded as follows: op bit 0 selects subtract, op bit 1 selects the 32-bit form, and op bits 3:2 select the scale (0 = none, 1 = shift by 2, 2 = shift by 3). The 64-bit codes are 0, 1, 4, 5, 8 and 9.
- R2: The 32-bit forms (codes 2, 3, 6, 7, 10, 11) compute the same 64-bit value as R1. Result bits 63:32 are then replaced by copies of bit 31.
- R3: The compares write exactly 1 when the test holds and 0 otherwise. Codes: 12 equal, 13 signed A≤B, 14 signed A<B, 15 unsigned A≤B, 16 unsigned A<B.
- R4: The logic group. Codes: 17 A AND B, 18 A AND NOT B, 19 A OR B, 20 NOT(A XOR B), 21 A OR NOT B, 22 A XOR B.
- R5: The shifts move A by the amount in the low 6 bits of B; the upper bits of B are ignored. Codes: 23 logical left, 24 logical right, 25 arithmetic right.
- R6: The conditional moves (codes 26..33) put B on the result and raise the write-enable only when the test on A holds. Codes: 26 A=0, 27 A≠0, 28 bit 0 of A clear, 29 bit 0 of A set, 30 A≥0, 31 A>0, 32 A≤0, 33 A<0 (all signed). Every operation with a code of 0..25 raises the write-enable.
- R7: When `in_lit_en` is 1, operand B is `in_lit` zero-extended to 64 bits, and `in_b_data` is ignored.
- R8: A source index of 31 reads as zero, whatever the data on the matching data port.
- R9: An operation accepted on an edge appears on the output at that edge, with `out_valid` high. When there is no accept and the output is drained, `out_valid` falls.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low. In that state `out_result` and `out_wr_en` hold their values.
- R11: A synchronous reset clears `out_valid`, `out_result` and `out_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation is present |
| in_ready | output | 1 | Stage can take an operation |
| in_op | input | 6 | Operation code |
| in_a_idx | input | 5 | Register index of operand A |
| in_a_data | input | 64 | Register data for operand A |
| in_b_idx | input | 5 | Register index of operand B |
| in_b_data | input | 64 | Register data for operand B |
| in_lit_en | input | 1 | Use the immediate as operand B |
| in_lit | input | 8 | Immediate value for operand B |
| out_valid | output | 1 | Result register holds an operation |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Result value |
| out_wr_en | output | 1 | Destination write-enable |

## Verification
The in-RTL properties watch every cycle for four things:

- the stream contract: an accept produces valid output, an idle drain empties the stage, and stalled output holds still;
- the sign replication of 32-bit results;
- the 0/1 shape of compare results;
- a raised write-enable for every operation outside the move group.

Only the bench scenarios can show the following:

- the numeric correctness of each operation;
- the predicate decisions for the moves;
- literal and zero-register operand selection;
- the masking of the shift amount;
- the effect of reset on a loaded output.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int OP_W = 6;

  typedef enum logic [OP_W-1:0] {
    OP_ADD64    = 6'd0,  OP_SUB64    = 6'd1,  OP_ADD32    = 6'd2,  OP_SUB32    = 6'd3,
    OP_SADD4_64 = 6'd4,  OP_SSUB4_64 = 6'd5,  OP_SADD4_32 = 6'd6,  OP_SSUB4_32 = 6'd7,
    OP_SADD8_64 = 6'd8,  OP_SSUB8_64 = 6'd9,  OP_SADD8_32 = 6'd10, OP_SSUB8_32 = 6'd11,
    OP_CEQ      = 6'd12, OP_CSLE     = 6'd13, OP_CSLT     = 6'd14, OP_CULE     = 6'd15,
    OP_CULT     = 6'd16,
    OP_AND      = 6'd17, OP_ANDN     = 6'd18, OP_OR       = 6'd19, OP_XNOR     = 6'd20,
    OP_ORN      = 6'd21, OP_XOR      = 6'd22,
    OP_SHL      = 6'd23, OP_SHR      = 6'd24, OP_SAR      = 6'd25,
    OP_MV_Z     = 6'd26, OP_MV_NZ    = 6'd27, OP_MV_EVEN  = 6'd28, OP_MV_ODD   = 6'd29,
    OP_MV_GEZ   = 6'd30, OP_MV_GTZ   = 6'd31, OP_MV_LEZ   = 6'd32, OP_MV_LTZ   = 6'd33
  } iex_op_e;

  typedef enum logic [1:0] {
    SC_X1 = 2'd0,
    SC_X4 = 2'd1,
    SC_X8 = 2'd2
  } iex_scale_e;

  typedef enum logic [2:0] {
    CL_ARITH,
    CL_CMP,
    CL_LOGIC,
    CL_MOVE,
    CL_NONE
  } iex_class_e;

  function automatic iex_class_e op_class(logic [OP_W-1:0] o);
    if (o <= OP_SSUB8_32)   return CL_ARITH;
    else if (o <= OP_CULT)  return CL_CMP;
    else if (o <= OP_SAR)   return CL_LOGIC;
    else if (o <= OP_MV_LTZ) return CL_MOVE;
    else                    return CL_NONE;
  endfunction
endpackage

// File: rtl/iex_operand_sel.sv
module iex_operand_sel #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int LIT_W  = 8
) (
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  input  logic              lit_en,
  input  logic [LIT_W-1:0]  lit,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  // The all-ones index is the hard-wired zero register.
  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  logic [DATA_W-1:0] b_reg;

  always_comb begin
    a_val = (a_idx == ZERO_IDX) ? '0 : a_data;
    b_reg = (b_idx == ZERO_IDX) ? '0 : b_data;
    b_val = lit_en ? {{(DATA_W-LIT_W){1'b0}}, lit} : b_reg;
  end
endmodule

// File: rtl/iex_addsub.sv
module iex_addsub #(
  parameter int DATA_W = 64
) (
  input  logic [iex_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic [DATA_W-1:0]        res
);
  import iex_pkg::*;
  localparam int HALF = DATA_W / 2;

  iex_scale_e        scale;
  logic [DATA_W-1:0] a_sc;
  logic [DATA_W-1:0] raw;

  always_comb begin
    scale = iex_scale_e'(op[3:2]);
    case (scale)
      SC_X4:   a_sc = a << 2;
      SC_X8:   a_sc = a << 3;
      default: a_sc = a;
    endcase
    raw = op[0] ? (a_sc - b) : (a_sc + b);
    res = op[1] ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
  end
endmodule

// File: rtl/iex_compare.sv
module iex_compare #(
  parameter int DATA_W = 64
) (
  input  logic [iex_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic [DATA_W-1:0]        res
);
  import iex_pkg::*;

  logic eq;
  logic slt;
  logic ult;
  logic hit;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    case (op)
      OP_CEQ:  hit = eq;
      OP_CSLE: hit = slt | eq;
      OP_CSLT: hit = slt;
      OP_CULE: hit = ult | eq;
      OP_CULT: hit = ult;
      default: hit = 1'b0;
    endcase
    res = {{(DATA_W-1){1'b0}}, hit};
  end
endmodule

// File: rtl/iex_logic_shift.sv
module iex_logic_shift #(
  parameter int DATA_W = 64
) (
  input  logic [iex_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]        a,
  input  logic [DATA_W-1:0]        b,
  output logic [DATA_W-1:0]        res
);
  import iex_pkg::*;
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] sh;

  always_comb begin
    sh = b[SH_W-1:0];
    case (op)
      OP_AND:  res = a & b;
      OP_ANDN: res = a & ~b;
      OP_OR:   res = a | b;
      OP_XNOR: res = ~(a ^ b);
      OP_ORN:  res = a | ~b;
      OP_XOR:  res = a ^ b;
      OP_SHL:  res = a << sh;
      OP_SHR:  res = a >> sh;
      OP_SAR:  res = DATA_W'($signed(a) >>> sh);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/iex_move_pred.sv
module iex_move_pred #(
  parameter int DATA_W = 64
) (
  input  logic [iex_pkg::OP_W-1:0] op,
  input  logic [DATA_W-1:0]        a,
  output logic                     take
);
  import iex_pkg::*;

  logic zero;
  logic neg;

  always_comb begin
    zero = (a == '0);
    neg  = a[DATA_W-1];
    case (op)
      OP_MV_Z:    take = zero;
      OP_MV_NZ:   take = !zero;
      OP_MV_EVEN: take = !a[0];
      OP_MV_ODD:  take = a[0];
      OP_MV_GEZ:  take = !neg;
      OP_MV_GTZ:  take = !neg && !zero;
      OP_MV_LEZ:  take = neg || zero;
      OP_MV_LTZ:  take = neg;
      default:    take = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 5,
  parameter int LIT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [iex_pkg::OP_W-1:0] in_op,
  input  logic [IDX_W-1:0]         in_a_idx,
  input  logic [DATA_W-1:0]        in_a_data,
  input  logic [IDX_W-1:0]         in_b_idx,
  input  logic [DATA_W-1:0]        in_b_data,
  input  logic                     in_lit_en,
  input  logic [LIT_W-1:0]         in_lit,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_result,
  output logic                     out_wr_en
);
  import iex_pkg::*;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] a_val, b_val;
  logic [DATA_W-1:0] arith_res, cmp_res, ls_res;
  logic              mv_take;
  iex_class_e        cls;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_we;
  logic              fire;

  iex_operand_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LIT_W(LIT_W)) u_opsel (
    .a_idx(in_a_idx), .a_data(in_a_data), .b_idx(in_b_idx), .b_data(in_b_data),
    .lit_en(in_lit_en), .lit(in_lit), .a_val(a_val), .b_val(b_val)
  );

  iex_addsub #(.DATA_W(DATA_W)) u_addsub (
    .op(in_op), .a(a_val), .b(b_val), .res(arith_res)
  );

  iex_compare #(.DATA_W(DATA_W)) u_cmp (
    .op(in_op), .a(a_val), .b(b_val), .res(cmp_res)
  );

  iex_logic_shift #(.DATA_W(DATA_W)) u_ls (
    .op(in_op), .a(a_val), .b(b_val), .res(ls_res)
  );

  iex_move_pred #(.DATA_W(DATA_W)) u_mv (
    .op(in_op), .a(a_val), .take(mv_take)
  );

  always_comb begin
    cls = op_class(in_op);
    case (cls)
      CL_ARITH: begin nxt_res = arith_res; nxt_we = 1'b1;    end
      CL_CMP:   begin nxt_res = cmp_res;   nxt_we = 1'b1;    end
      CL_LOGIC: begin nxt_res = ls_res;    nxt_we = 1'b1;    end
      CL_MOVE:  begin nxt_res = b_val;     nxt_we = mv_take; end
      default:  begin nxt_res = '0;        nxt_we = 1'b0;    end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
    end else if (fire) begin
      out_valid  <= 1'b1;
      out_result <= nxt_res;
      out_wr_en  <= nxt_we;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // Helper flags for the checks below.
  logic fire_long, fire_cmp, fire_plain;
  always_comb begin
    fire_long  = fire && (cls == CL_ARITH) && in_op[1];
    fire_cmp   = fire && (cls == CL_CMP);
    fire_plain = fire && (cls == CL_ARITH || cls == CL_CMP || cls == CL_LOGIC);
  end

  p_fire_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (!fire && out_ready) |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wr_en)));

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_sext_r2: assert property (@(posedge clk) disable iff (rst)
    fire_long |=> (out_result[DATA_W-1:HALF] == {HALF{out_result[HALF-1]}}));

  p_cmp01_r3: assert property (@(posedge clk) disable iff (rst)
    fire_cmp |=> (out_result[DATA_W-1:1] == '0));

  p_wren_r6: assert property (@(posedge clk) disable iff (rst)
    fire_plain |=> out_wr_en);
endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 30;

  typedef struct packed {
    logic [5:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] res;
    logic        we;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

  localparam vec_t TBL [NV] = '{
    '{6'd0,  64'd5,                 64'd7,     64'd12,                    1'b1},
    '{6'd1,  64'd3,                 64'd5,     64'hFFFF_FFFF_FFFF_FFFE,   1'b1},
    '{6'd2,  64'h7FFF_FFFF,         64'd1,     64'hFFFF_FFFF_8000_0000,   1'b1},
    '{6'd3,  64'h1_0000_0005,       64'd3,     64'd2,                     1'b1},
    '{6'd4,  64'd3,                 64'd1,     64'd13,                    1'b1},
    '{6'd9,  64'd2,                 64'd1,     64'd15,                    1'b1},
    '{6'd7,  64'h2000_0000,         64'd0,     64'hFFFF_FFFF_8000_0000,   1'b1},
    '{6'd10, 64'd1,                 64'd2,     64'd10,                    1'b1},
    '{6'd12, 64'd9,                 64'd9,     64'd1,                     1'b1},
    '{6'd14, ONES,                  64'd0,     64'd1,                     1'b1},
    '{6'd16, ONES,                  64'd0,     64'd0,                     1'b1},
    '{6'd13, 64'd4,                 64'd4,     64'd1,                     1'b1},
    '{6'd15, 64'd5,                 64'd4,     64'd0,                     1'b1},
    '{6'd17, 64'hF0F0,              64'hFF00,  64'hF000,                  1'b1},
    '{6'd18, 64'hFF,                64'h0F,    64'hF0,                    1'b1},
    '{6'd19, 64'hF0,                64'h0F,    64'hFF,                    1'b1},
    '{6'd20, 64'd0,                 64'd0,     ONES,                      1'b1},
    '{6'd21, 64'd0,                 ONES,      64'd0,                     1'b1},
    '{6'd22, 64'hFF,                64'h0F,    64'hF0,                    1'b1},
    '{6'd23, 64'd1,                 64'h44,    64'h10,                    1'b1},
    '{6'd24, MSB,                   64'd63,    64'd1,                     1'b1},
    '{6'd25, MSB,                   64'd4,     64'hF800_0000_0000_0000,   1'b1},
    '{6'd26, 64'd0,                 64'h55,    64'h55,                    1'b1},
    '{6'd27, 64'd0,                 64'h55,    64'h55,                    1'b0},
    '{6'd28, 64'd2,                 64'h66,    64'h66,                    1'b1},
    '{6'd29, 64'd2,                 64'h66,    64'h66,                    1'b0},
    '{6'd31, ONES,                  64'h77,    64'h77,                    1'b0},
    '{6'd33, ONES,                  64'h77,    64'h77,                    1'b1},
    '{6'd30, 64'd0,                 64'h88,    64'h88,                    1'b1},
    '{6'd32, 64'd1,                 64'h88,    64'h88,                    1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [4:0]  in_a_idx = 5'd1;
  logic [63:0] in_a_data = '0;
  logic [4:0]  in_b_idx = 5'd2;
  logic [63:0] in_b_data = '0;
  logic        in_lit_en = 1'b0;
  logic [7:0]  in_lit = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_wr_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_exec_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a_idx(in_a_idx), .in_a_data(in_a_data), .in_b_idx(in_b_idx), .in_b_data(in_b_data),
    .in_lit_en(in_lit_en), .in_lit(in_lit), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wr_en(out_wr_en)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] op, logic [63:0] a, logic [63:0] b);
    in_op = op; in_a_data = a; in_b_data = b; in_valid = 1'b1;
  endtask

  // One operation through the stage: accept at the next edge, sample after it.
  task automatic run_one(logic [5:0] op, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    drive(op, a, b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic string tag_of(logic [5:0] op);
    if (op <= 6'd11) return op[1] ? "R2" : "R1";
    if (op <= 6'd16) return "R3";
    if (op <= 6'd22) return "R4";
    if (op <= 6'd25) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: state held in reset
    repeat (3) @(negedge clk);
    chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R11 reset result", out_result, 64'd0);
    chk("R11 reset wr_en", {63'd0, out_wr_en}, 64'd0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      run_one(TBL[i].op, TBL[i].a, TBL[i].b);
      chk("R9 valid after accept", {63'd0, out_valid}, 64'd1);
      chk(tag_of(TBL[i].op), out_result, TBL[i].res);
      chk({tag_of(TBL[i].op), " wr_en"}, {63'd0, out_wr_en}, {63'd0, TBL[i].we});
    end

    // R7: literal replaces register B, zero-extended
    in_lit_en = 1'b1; in_lit = 8'hFF;
    run_one(6'd0, 64'd1, ONES);
    chk("R7 literal operand", out_result, 64'h100);
    in_lit_en = 1'b0;

    // R8: index 31 reads as zero on A and on B
    in_a_idx = 5'd31;
    run_one(6'd0, 64'd123, 64'd5);
    chk("R8 zero A", out_result, 64'd5);
    in_a_idx = 5'd1; in_b_idx = 5'd31;
    run_one(6'd19, 64'h10, 64'd77);
    chk("R8 zero B", out_result, 64'h10);
    in_b_idx = 5'd2;

    // R10: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive(6'd0, 64'd1, 64'd1);
    @(negedge clk);
    drive(6'd0, 64'd10, 64'd10);
    chk("R10 ready low on stall", {63'd0, in_ready}, 64'd0);
    chk("R10 first result", out_result, 64'd2);
    @(negedge clk);
    chk("R10 result held", out_result, 64'd2);
    chk("R10 valid held", {63'd0, out_valid}, 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second taken on drain", out_result, 64'd20);
    @(negedge clk);
    chk("R9 empty after drain", {63'd0, out_valid}, 64'd0);

    // R11: reset clears a loaded output
    out_ready = 1'b0;
    run_one(6'd26, 64'd0, 64'h99);
    chk("R11 loaded before reset", {63'd0, out_wr_en}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 valid cleared", {63'd0, out_valid}, 64'd0);
    chk("R11 result cleared", out_result, 64'd0);
    chk("R11 wr_en cleared", {63'd0, out_wr_en}, 64'd0);
    rst = 1'b0; out_ready = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule